// File: doc/BRIEF.md
# Secure Dual RAM Bank Swap Remapper

This block sits between a CPU-side memory bus and two physical RAM banks of equal size. Two adjacent logical windows, A at 0x8000–0x87FF and B at 0x8800–0x8FFF, are served either straight (bank 1 behind A, bank 2 behind B) or crossed. Software writes a swap control bit. The block qualifies each write against the banks' security setup, the origin of the request and the readiness of both banks. An accepted write is committed to the mapping on the next clock edge. A read-only status bit shows the mapping that is actually in force. When a write is rejected, the control bit and the status bit disagree, and software can restore agreement by writing the control bit back.

Each physical bank carries four attribute bits: master select, fetch protect, write protect and program-memory flag. The block presents these bits per logical window, so they travel with the bank. The address sent to error-correction logic is always the physical bank address. Bus accesses outside both windows are forwarded unchanged.

Top module: `bank_swap_remap`

## Requirements
- R1: After reset, swap_ctrl and swap_status are 0. Window A selects bank 1 and window B selects bank 2.
- R2: With swap_status=0, a valid access in window A asserts bank1_sel, and a valid access in window B asserts bank2_sel. bank_offset equals address bits [10:0].
- R3: With swap_status=1, a valid access in window A asserts bank2_sel, and a valid access in window B asserts bank1_sel.
- R4: A write to the control bit updates swap_ctrl on the next edge. An accepted write updates swap_status on that same edge. Without an accepted write, swap_status holds its value.
- R5: A write is rejected when the two banks' zone codes differ or their execute-protect bits differ.
- R6: Zone codes are 0 for unsecure, 1 for zone 1 and 2 for zone 2. When both banks are in a locked secure zone, the write is rejected if req_zone differs from that zone or if req_debug is 1.
- R7: When both banks are unsecure (zone 0), or their zone is unlocked, the write is accepted from any req_zone, including with req_debug=1. zone_unlock bit 0 unlocks zone 1 and bit 1 unlocks zone 2.
- R8: A write is rejected while init_done is not 2'b11 or while any self_test bit is 1. A rejected write still sets swap_ctrl, so it differs from swap_status. Writing swap_ctrl back to the status value makes the two agree again.
- R9: win_a_attr and win_b_attr present the attributes of the bank serving each window. Attribute bits are [0] master select, [1] fetch protect, [2] write protect, [3] program memory.
- R10: ecc_addr is the physical address: 0x8000+offset for bank 1 and 0x8800+offset for bank 2, whatever the mapping. Outside the windows it is 0.
- R11: A valid access outside both windows asserts fwd_valid, drives fwd_addr equal to bus_addr, and asserts no bank select.
- R12: bank1_sel and bank2_sel are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the swap control bit |
| ctrl_wdata | input | 1 | Value written to the swap control bit |
| bank1_zone | input | 2 | Security zone code of bank 1 |
| bank2_zone | input | 2 | Security zone code of bank 2 |
| bank1_exe | input | 1 | Execute-protect setting of bank 1 |
| bank2_exe | input | 1 | Execute-protect setting of bank 2 |
| zone_unlock | input | 2 | Unlock flags for zone 1 (bit 0) and zone 2 (bit 1) |
| req_zone | input | 2 | Zone of the code issuing the write |
| req_debug | input | 1 | Write comes from a debug master |
| init_done | input | 2 | Initialization complete, one bit per bank |
| self_test | input | 2 | RAM self-test active, one bit per bank |
| bus_addr | input | 16 | Bus address |
| bus_valid | input | 1 | Bus access valid |
| bank1_phys_attr | input | 4 | Attribute bits of physical bank 1 |
| bank2_phys_attr | input | 4 | Attribute bits of physical bank 2 |
| swap_ctrl | output | 1 | Software swap control bit |
| swap_status | output | 1 | Mapping in force (1 = crossed) |
| bank1_sel | output | 1 | Bank 1 selected |
| bank2_sel | output | 1 | Bank 2 selected |
| bank_offset | output | 11 | Offset within the selected bank |
| fwd_valid | output | 1 | Access forwarded outside the windows |
| fwd_addr | output | 16 | Forwarded address |
| ecc_addr | output | 16 | Physical address for error-correction logic |
| win_a_attr | output | 4 | Attributes of the bank serving window A |
| win_b_attr | output | 4 | Attributes of the bank serving window B |

## Verification
Only swap_ctrl and swap_status are registered. Each is due at the first clock edge after the cycle that carries ctrl_wr, so the bench raises the write at a falling edge and reads both bits at the next falling edge. All decode, ECC-address and attribute outputs are combinational from the bus inputs and swap_status. The bench therefore checks them a few nanoseconds after it drives the inputs, within the same low clock phase, and never straddles an edge. After each rejected write, the bench confirms through the bank selects that the mapping has not moved.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int ADDR_W_DEF = 16;
  localparam int OFS_W_DEF  = 11;
  localparam int ATTR_W_DEF = 4;

  typedef logic [1:0] zone_t;
  localparam zone_t ZONE_OPEN = 2'd0;

  // Origin check for a swap write; bank_z is the zone shared by both banks.
  function automatic logic origin_ok(zone_t bank_z, logic [1:0] unlock,
                                     zone_t req_z, logic dbg);
    logic unlocked;
    case (bank_z)
      2'd1:    unlocked = unlock[0];
      2'd2:    unlocked = unlock[1];
      default: unlocked = 1'b0;
    endcase
    if (bank_z == ZONE_OPEN || unlocked) return 1'b1;
    return (!dbg) && (req_z == bank_z);
  endfunction

  // Physical bank index serving a logical window index.
  function automatic logic phys_of(logic win_idx, logic crossed);
    return win_idx ^ crossed;
  endfunction
endpackage

// File: rtl/swap_gate.sv
module swap_gate
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       ctrl_wdata,
  input  zone_t      bank1_zone,
  input  zone_t      bank2_zone,
  input  logic       bank1_exe,
  input  logic       bank2_exe,
  input  logic [1:0] zone_unlock,
  input  zone_t      req_zone,
  input  logic       req_debug,
  input  logic [1:0] init_done,
  input  logic [1:0] self_test,
  output logic       swap_ctrl,
  output logic       swap_status,
  output logic       swap_accept
);
  logic cfg_match, banks_ready, origin_pass;

  assign cfg_match   = (bank1_zone == bank2_zone) && (bank1_exe == bank2_exe);
  assign banks_ready = (&init_done) && !(|self_test);
  assign origin_pass = origin_ok(bank1_zone, zone_unlock, req_zone, req_debug);
  assign swap_accept = ctrl_wr && cfg_match && banks_ready && origin_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_ctrl   <= 1'b0;
      swap_status <= 1'b0;
    end else begin
      if (ctrl_wr)     swap_ctrl   <= ctrl_wdata;
      if (swap_accept) swap_status <= ctrl_wdata;
    end
  end

  p_ctrl_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> swap_ctrl == $past(ctrl_wdata));
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_accept |=> swap_status == $past(ctrl_wdata));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_accept |=> $stable(swap_status));
  p_cfg_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (bank1_zone != bank2_zone || bank1_exe != bank2_exe)) |-> !swap_accept);
  p_ready_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (init_done != 2'b11 || self_test != 2'b00)) |-> !swap_accept);
  p_debug_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && req_debug && bank1_zone == 2'd1 && !zone_unlock[0]) |-> !swap_accept);
endmodule

// File: rtl/win_decode.sv
module win_decode
  import bsr_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int OFS_W  = OFS_W_DEF,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  input  logic              crossed,
  output logic [1:0]        bank_sel,
  output logic [OFS_W-1:0]  bank_offset,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [ADDR_W-1:0] ecc_addr
);
  localparam int HI_W = ADDR_W - OFS_W - 1;
  localparam logic [HI_W-1:0] BASE_HI = WIN_BASE[ADDR_W-1:OFS_W+1];

  logic in_pair, win_idx, phys_idx;

  assign in_pair     = (bus_addr[ADDR_W-1:OFS_W+1] == BASE_HI);
  assign win_idx     = bus_addr[OFS_W];
  assign phys_idx    = phys_of(win_idx, crossed);
  assign bank_offset = bus_addr[OFS_W-1:0];
  assign bank_sel    = (bus_valid && in_pair) ? (2'b01 << phys_idx) : 2'b00;
  assign fwd_valid   = bus_valid && !in_pair;
  assign fwd_addr    = bus_addr;
  assign ecc_addr    = in_pair ? {BASE_HI, phys_idx, bank_offset} : '0;

  always_comb begin
    p_fwd_excl_r11: assert (!(fwd_valid && (|bank_sel)));
  end
endmodule

// File: rtl/attr_xbar.sv
module attr_xbar
  import bsr_pkg::*;
#(
  parameter int ATTR_W = ATTR_W_DEF
) (
  input  logic              crossed,
  input  logic [ATTR_W-1:0] phys_attr [2],
  output logic [ATTR_W-1:0] win_attr  [2]
);
  for (genvar w = 0; w < 2; w++) begin : g_win
    logic src;
    assign src         = phys_of(w[0], crossed);
    assign win_attr[w] = phys_attr[src];
  end
endmodule

// File: rtl/bank_swap_remap.sv
module bank_swap_remap
  import bsr_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int OFS_W  = OFS_W_DEF,
  parameter int ATTR_W = ATTR_W_DEF,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_wdata,
  input  logic [1:0]        bank1_zone,
  input  logic [1:0]        bank2_zone,
  input  logic              bank1_exe,
  input  logic              bank2_exe,
  input  logic [1:0]        zone_unlock,
  input  logic [1:0]        req_zone,
  input  logic              req_debug,
  input  logic [1:0]        init_done,
  input  logic [1:0]        self_test,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  input  logic [ATTR_W-1:0] bank1_phys_attr,
  input  logic [ATTR_W-1:0] bank2_phys_attr,
  output logic              swap_ctrl,
  output logic              swap_status,
  output logic              bank1_sel,
  output logic              bank2_sel,
  output logic [OFS_W-1:0]  bank_offset,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [ADDR_W-1:0] ecc_addr,
  output logic [ATTR_W-1:0] win_a_attr,
  output logic [ATTR_W-1:0] win_b_attr
);
  logic              swap_accept;
  logic [1:0]        bank_sel;
  logic [ATTR_W-1:0] phys_attr [2];
  logic [ATTR_W-1:0] win_attr  [2];

  swap_gate u_gate (
    .clk, .rst_n, .ctrl_wr, .ctrl_wdata,
    .bank1_zone, .bank2_zone, .bank1_exe, .bank2_exe,
    .zone_unlock, .req_zone, .req_debug, .init_done, .self_test,
    .swap_ctrl, .swap_status, .swap_accept
  );

  win_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)) u_dec (
    .bus_addr, .bus_valid, .crossed(swap_status), .bank_sel,
    .bank_offset, .fwd_valid, .fwd_addr, .ecc_addr
  );

  assign phys_attr[0] = bank1_phys_attr;
  assign phys_attr[1] = bank2_phys_attr;

  attr_xbar #(.ATTR_W(ATTR_W)) u_attr (
    .crossed(swap_status), .phys_attr, .win_attr
  );

  assign bank1_sel  = bank_sel[0];
  assign bank2_sel  = bank_sel[1];
  assign win_a_attr = win_attr[0];
  assign win_b_attr = win_attr[1];

  p_sel_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank1_sel && bank2_sel));
  p_attr_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_status |-> (win_a_attr == bank2_phys_attr && win_b_attr == bank1_phys_attr));
  p_ecc_phys_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bank1_sel |-> ecc_addr[OFS_W] == 1'b0);
endmodule

// File: tb/bank_swap_remap_tb.sv
module bank_swap_remap_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0, ctrl_wdata = 1'b0;
  logic [1:0] bank1_zone = 2'd0, bank2_zone = 2'd0, zone_unlock = 2'b00;
  logic [1:0] req_zone = 2'd0, init_done = 2'b11, self_test = 2'b00;
  logic bank1_exe = 1'b0, bank2_exe = 1'b0, req_debug = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic bus_valid = 1'b0;
  logic [3:0] bank1_phys_attr = 4'b0101, bank2_phys_attr = 4'b1010;
  logic swap_ctrl, swap_status, bank1_sel, bank2_sel, fwd_valid;
  logic [10:0] bank_offset;
  logic [15:0] fwd_addr, ecc_addr;
  logic [3:0] win_a_attr, win_b_attr;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bank_swap_remap dut_i (.*);

  // {straight bank (0 = outside), address}
  localparam logic [17:0] VEC [9] = '{
    {2'd1, 16'h8000}, {2'd1, 16'h87FF}, {2'd2, 16'h8800}, {2'd2, 16'h8FFF},
    {2'd1, 16'h8432}, {2'd0, 16'h7FFF}, {2'd0, 16'h9000}, {2'd0, 16'h0000},
    {2'd0, 16'hFFFF}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(logic v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0; #1;
  endtask

  task automatic walk(logic crossed, string req);
    for (int i = 0; i < 9; i++) begin
      logic [1:0] b;
      logic [15:0] a, exp_ecc;
      a = VEC[i][15:0];
      b = VEC[i][17:16];
      if (crossed && b != 0) b = 2'd3 - b;
      exp_ecc = (b == 1) ? 16'h8000 + (a & 16'h07FF)
              : (b == 2) ? 16'h8800 + (a & 16'h07FF) : 16'h0000;
      @(negedge clk); bus_addr = a; bus_valid = 1'b1; #2;
      chk(req, {bank2_sel, bank1_sel}, {b == 2, b == 1});
      chk("R10", ecc_addr, exp_ecc);
      chk("R12", bank1_sel & bank2_sel, 0);
      if (b == 0) begin
        chk("R11", {fwd_valid, fwd_addr}, {1'b1, a});
      end else begin
        chk("R2 offset", bank_offset, a[10:0]);
        chk("R11 no fwd", fwd_valid, 0);
      end
    end
    bus_valid = 1'b0;
  endtask

  // Current mapping seen through window A: 1 if bank 2 serves it.
  task automatic map_check(string req, logic exp_crossed);
    @(negedge clk); bus_addr = 16'h8010; bus_valid = 1'b1; #2;
    chk(req, {bank2_sel, bank1_sel}, exp_crossed ? 2'b10 : 2'b01);
    bus_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ctrl", swap_ctrl, 0);
    chk("R1 status", swap_status, 0);
    map_check("R1 map", 1'b0);

    walk(1'b0, "R2");
    chk("R9 straight", {win_a_attr, win_b_attr}, {4'b0101, 4'b1010});

    write_ctrl(1'b1);
    chk("R4 ctrl", swap_ctrl, 1);
    chk("R4 status", swap_status, 1);
    walk(1'b1, "R3");
    chk("R9 crossed", {win_a_attr, win_b_attr}, {4'b1010, 4'b0101});

    // R5: zones differ
    bank1_zone = 2'd1; bank2_zone = 2'd2;
    write_ctrl(1'b0);
    chk("R5 zone ctrl", swap_ctrl, 0);
    chk("R5 zone status", swap_status, 1);
    map_check("R5 map", 1'b1);
    bank1_zone = 2'd0; bank2_zone = 2'd0;
    write_ctrl(1'b1);
    chk("R8 resync", {swap_ctrl, swap_status}, 2'b11);
    // R5: execute protection differs
    bank1_exe = 1'b1;
    write_ctrl(1'b0);
    chk("R5 exe status", swap_status, 1);
    bank1_exe = 1'b0;
    write_ctrl(1'b1);

    // R6: both in locked zone 1
    bank1_zone = 2'd1; bank2_zone = 2'd1;
    req_zone = 2'd2; write_ctrl(1'b0);
    chk("R6 other zone", swap_status, 1);
    req_zone = 2'd0; write_ctrl(1'b0);
    chk("R6 unsecure code", swap_status, 1);
    req_zone = 2'd1; req_debug = 1'b1; write_ctrl(1'b0);
    chk("R6 debug", swap_status, 1);
    req_debug = 1'b0; write_ctrl(1'b0);
    chk("R6 same zone", {swap_ctrl, swap_status}, 2'b00);
    map_check("R6 map", 1'b0);

    // R7: zone 2 unlocked, debug from unsecure accepted
    bank1_zone = 2'd2; bank2_zone = 2'd2; zone_unlock = 2'b10;
    req_zone = 2'd0; req_debug = 1'b1; write_ctrl(1'b1);
    chk("R7 unlocked", swap_status, 1);
    zone_unlock = 2'b00; bank1_zone = 2'd0; bank2_zone = 2'd0;
    req_zone = 2'd2; write_ctrl(1'b0);
    chk("R7 open", swap_status, 0);
    req_debug = 1'b0;

    // R8: readiness
    init_done = 2'b01; write_ctrl(1'b1);
    chk("R8 init", {swap_ctrl, swap_status}, 2'b10);
    map_check("R8 map", 1'b0);
    init_done = 2'b11; write_ctrl(1'b0);
    chk("R8 resync", {swap_ctrl, swap_status}, 2'b00);
    self_test = 2'b10; write_ctrl(1'b1);
    chk("R8 test", swap_status, 0);
    self_test = 2'b00; write_ctrl(1'b1);
    chk("R8 ready again", swap_status, 1);

    // R4: no write, status holds
    repeat (3) @(negedge clk);
    chk("R4 hold", swap_status, 1);

    // R1: reset mid-run
    rst_n = 1'b0; #1;
    chk("R1 async reset", {swap_ctrl, swap_status}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    map_check("R1 map after reset", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule